// File: doc/BRIEF.md
# Spill-Gated Trigger Former with Busy Interlock

This block forms the trigger for a beam-test readout from discriminated counter signals. Two scintillator trigger counters must fire together while the veto counter is quiet and the beam spill is on; outside the spill a pedestal source supplies random triggers for baseline runs, and a separate pedestal veto can suppress them. Either kind of accepted trigger opens a gate of programmable length for the charge and time digitizers. It also fires a one-cycle trigger for the waveform digitizer.

Each accepted trigger sets a busy interlock that blocks every later trigger. The acquisition computer reads all modules after an accepted trigger, stores the event and then pulses re-enable, which clears busy. Every asynchronous input is synchronized with two flip-flops, and edge inputs are reduced to one event per rising edge. Three saturating monitor counters record accepted beam triggers, accepted pedestal triggers and valid beam coincidences that arrived while busy. A synchronous clear input zeroes all three counters.

Top module: `spill_trig_top`

## Requirements
- R1: A rising edge of the AND of both trigger counters, with veto low, spill high and busy low, produces a one-cycle accept_o pulse on the third rising clock edge after the inputs change.
- R2: No beam trigger is accepted while the veto counter is high, or when only one of the two trigger counters fires.
- R3: A rising pedestal edge is accepted only while spill is low and the pedestal veto is low. A beam coincidence is accepted only while spill is high.
- R4: busy_o rises in the same cycle as accept_o and stays high until a rising re-enable edge. busy_o falls on the third clock edge after re-enable rises.
- R5: While busy_o is high, no trigger is accepted. Each valid beam coincidence (veto low, spill high) that arrives while busy adds one to lost_cnt_o.
- R6: gate_o goes high together with accept_o and stays high for gate_width_i cycles. A width of 0 gives a single-cycle gate.
- R7: wave_trig_o pulses in exactly the same cycles as accept_o. ped_kind_o is 1 during a pedestal accept and 0 during a beam accept.
- R8: Each rising input edge counts once. A coincidence that is still held when busy clears does not retrigger; the counters must drop and rise again.
- R9: beam_cnt_o and ped_cnt_o count the accepted triggers of each kind. A high cnt_clr_i sets all three counters to 0 on the next clock edge.
- R10: After reset, accept_o, gate_o, wave_trig_o, busy_o and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_clr_i | input | 1 | Synchronous clear of the monitor counters |
| trg_a_i | input | 1 | First trigger counter, asynchronous |
| trg_b_i | input | 1 | Second trigger counter, asynchronous |
| veto_i | input | 1 | Veto counter level, asynchronous |
| spill_i | input | 1 | Spill-active level, asynchronous |
| ped_i | input | 1 | Pedestal trigger source, asynchronous |
| ped_veto_i | input | 1 | Pedestal veto level, asynchronous |
| rearm_i | input | 1 | Re-enable from acquisition, asynchronous |
| gate_width_i | input | GW_W | Gate length in clock cycles |
| accept_o | output | 1 | One-cycle accepted-trigger pulse |
| ped_kind_o | output | 1 | Accept is a pedestal trigger |
| gate_o | output | 1 | Gate to charge/time digitizers |
| wave_trig_o | output | 1 | Trigger to waveform digitizer |
| busy_o | output | 1 | Busy interlock |
| beam_cnt_o | output | CNT_W | Accepted beam triggers |
| ped_cnt_o | output | CNT_W | Accepted pedestal triggers |
| lost_cnt_o | output | CNT_W | Beam coincidences lost to busy |

## Verification
The checker watches the cycle-level invariants on every clock edge. These are: busy rising only with an accept, no accept following a busy cycle, the gate opening with each accept, single-cycle accepts, one-step counter movement, and lost counts only after a busy cycle. The bench scenarios are needed for the rest. They cover the exact three-edge latency, the suppression by veto, spill and pedestal veto, the gate length, and the non-retrigger of a held coincidence after re-enable. They also cover the final counter values and their clear. A scoreboard pairs every accept with the expected trigger kind.

// File: rtl/spill_trig_pkg.sv
package spill_trig_pkg;

    localparam int unsigned IX_TA    = 0;
    localparam int unsigned IX_TB    = 1;
    localparam int unsigned IX_VETO  = 2;
    localparam int unsigned IX_SPILL = 3;
    localparam int unsigned IX_PED   = 4;
    localparam int unsigned IX_PVETO = 5;
    localparam int unsigned IX_REARM = 6;
    localparam int unsigned N_ASYNC  = 7;

    typedef struct packed {
        logic both;      // registered coincidence level
        logic busy;      // interlock
        logic acc;       // accept pulse
        logic kind;      // 1 = pedestal
        logic beam_hit;  // accepted beam trigger
        logic ped_hit;   // accepted pedestal trigger
        logic lost;      // valid coincidence blocked by busy
    } core_st_t;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic lvl_o,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign lvl_o  = chain_q[LAST];
    assign rise_o = chain_q[LAST] & ~chain_q[STAGES];
endmodule

// File: rtl/trig_core.sv
module trig_core
    import spill_trig_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ta_lvl_i,
    input  logic tb_lvl_i,
    input  logic veto_lvl_i,
    input  logic spill_lvl_i,
    input  logic ped_rise_i,
    input  logic pveto_lvl_i,
    input  logic rearm_rise_i,
    output logic take_o,
    output logic acc_o,
    output logic kind_o,
    output logic busy_o,
    output logic beam_hit_o,
    output logic ped_hit_o,
    output logic lost_o
);
    core_st_t st_d, st_q;
    logic both_now, coinc, beam_ok, ped_ok, take_beam, take_ped;

    always_comb begin
        both_now  = ta_lvl_i & tb_lvl_i;
        coinc     = both_now & ~st_q.both;
        beam_ok   = coinc & ~veto_lvl_i & spill_lvl_i;
        ped_ok    = ped_rise_i & ~pveto_lvl_i & ~spill_lvl_i;
        take_beam = beam_ok & ~st_q.busy;
        take_ped  = ped_ok & ~st_q.busy & ~beam_ok;

        st_d          = st_q;
        st_d.both     = both_now;
        st_d.acc      = take_beam | take_ped;
        st_d.kind     = take_ped;
        st_d.beam_hit = take_beam;
        st_d.ped_hit  = take_ped;
        st_d.lost     = beam_ok & st_q.busy;
        if (take_beam | take_ped) st_d.busy = 1'b1;
        else if (rearm_rise_i)    st_d.busy = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign take_o     = st_d.acc;
    assign acc_o      = st_q.acc;
    assign kind_o     = st_q.kind;
    assign busy_o     = st_q.busy;
    assign beam_hit_o = st_q.beam_hit;
    assign ped_hit_o  = st_q.ped_hit;
    assign lost_o     = st_q.lost;
endmodule

// File: rtl/gate_stretch.sv
module gate_stretch #(
    parameter int unsigned GW_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            fire_i,
    input  logic [GW_W-1:0] width_i,
    output logic            gate_o
);
    localparam logic [GW_W-1:0] ONE = GW_W'(1);

    logic [GW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire_i)            cnt_d = (width_i == '0) ? ONE : width_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign gate_o = (cnt_q != '0);
endmodule

// File: rtl/evt_counters.sv
module evt_counters #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CNT = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        clr_i,
    input  logic [N_CNT-1:0]            inc_i,
    output logic [N_CNT-1:0][CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic [CNT_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (clr_i)                         val_d = '0;
            else if (inc_i[g] && val_q != CMAX) val_d = val_q + CNT_W'(1);
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) val_q <= '0;
            else         val_q <= val_d;
        end

        assign cnt_o[g] = val_q;
    end
endmodule

// File: rtl/spill_trig_top.sv
module spill_trig_top
    import spill_trig_pkg::*;
#(
    parameter int unsigned GW_W        = 8,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_clr_i,
    input  logic             trg_a_i,
    input  logic             trg_b_i,
    input  logic             veto_i,
    input  logic             spill_i,
    input  logic             ped_i,
    input  logic             ped_veto_i,
    input  logic             rearm_i,
    input  logic [GW_W-1:0]  gate_width_i,
    output logic             accept_o,
    output logic             ped_kind_o,
    output logic             gate_o,
    output logic             wave_trig_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] beam_cnt_o,
    output logic [CNT_W-1:0] ped_cnt_o,
    output logic [CNT_W-1:0] lost_cnt_o
);
    localparam int unsigned N_CNT = 3;

    logic [N_ASYNC-1:0] raw, lvl, rise;
    logic take, acc, kind, busy, beam_hit, ped_hit, lost;
    logic [N_CNT-1:0][CNT_W-1:0] cnts;

    assign raw[IX_TA]    = trg_a_i;
    assign raw[IX_TB]    = trg_b_i;
    assign raw[IX_VETO]  = veto_i;
    assign raw[IX_SPILL] = spill_i;
    assign raw[IX_PED]   = ped_i;
    assign raw[IX_PVETO] = ped_veto_i;
    assign raw[IX_REARM] = rearm_i;

    for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
        sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(raw[i]),
            .lvl_o  (lvl[i]),
            .rise_o (rise[i])
        );
    end

    trig_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ta_lvl_i    (lvl[IX_TA]),
        .tb_lvl_i    (lvl[IX_TB]),
        .veto_lvl_i  (lvl[IX_VETO]),
        .spill_lvl_i (lvl[IX_SPILL]),
        .ped_rise_i  (rise[IX_PED]),
        .pveto_lvl_i (lvl[IX_PVETO]),
        .rearm_rise_i(rise[IX_REARM]),
        .take_o      (take),
        .acc_o       (acc),
        .kind_o      (kind),
        .busy_o      (busy),
        .beam_hit_o  (beam_hit),
        .ped_hit_o   (ped_hit),
        .lost_o      (lost)
    );

    gate_stretch #(.GW_W(GW_W)) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fire_i (take),
        .width_i(gate_width_i),
        .gate_o (gate_o)
    );

    evt_counters #(.CNT_W(CNT_W), .N_CNT(N_CNT)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (cnt_clr_i),
        .inc_i ({lost, ped_hit, beam_hit}),
        .cnt_o (cnts)
    );

    assign accept_o    = acc;
    assign wave_trig_o = acc;
    assign ped_kind_o  = kind;
    assign busy_o      = busy;
    assign beam_cnt_o  = cnts[0];
    assign ped_cnt_o   = cnts[1];
    assign lost_cnt_o  = cnts[2];
endmodule

// File: rtl/spill_trig_chk.sv
module spill_trig_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cnt_clr_i,
    input logic             accept_o,
    input logic             gate_o,
    input logic             busy_o,
    input logic [CNT_W-1:0] beam_cnt_o,
    input logic [CNT_W-1:0] lost_cnt_o
);
    p_busy_with_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> busy_o);

    p_busy_rise_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> accept_o);

    p_no_accept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> !$past(busy_o));

    p_single_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> !accept_o);

    p_gate_opens_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |-> gate_o);

    p_gate_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> accept_o);

    p_beam_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(cnt_clr_i) && !$stable(beam_cnt_o)) |-> beam_cnt_o == CNT_W'($past(beam_cnt_o) + 1'b1));

    p_lost_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(cnt_clr_i) && !$stable(lost_cnt_o)) |-> $past(busy_o, 2));
endmodule

bind spill_trig_top spill_trig_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_clr_i (cnt_clr_i),
    .accept_o  (accept_o),
    .gate_o    (gate_o),
    .busy_o    (busy_o),
    .beam_cnt_o(beam_cnt_o),
    .lost_cnt_o(lost_cnt_o)
);

// File: tb/tb_spill_trig_top.sv
module tb_spill_trig_top;
    localparam int unsigned GW_W  = 8;
    localparam int unsigned CNT_W = 16;

    logic clk_i = 1'b0, rst_ni = 1'b0, cnt_clr_i = 1'b0;
    logic trg_a_i = 0, trg_b_i = 0, veto_i = 0, spill_i = 0;
    logic ped_i = 0, ped_veto_i = 0, rearm_i = 0;
    logic [GW_W-1:0] gate_width_i = 8'd4;
    logic accept_o, ped_kind_o, gate_o, wave_trig_o, busy_o;
    logic [CNT_W-1:0] beam_cnt_o, ped_cnt_o, lost_cnt_o;

    int total = 0, bad = 0;
    bit exp_q[$];

    always #5 clk_i = ~clk_i;

    spill_trig_top #(.GW_W(GW_W), .CNT_W(CNT_W)) dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic beam(input bit expect_acc);
        trg_a_i = 1; trg_b_i = 1;
        if (expect_acc) exp_q.push_back(1'b0);
        tick(6);
        trg_a_i = 0; trg_b_i = 0;
        tick(4);
    endtask

    task automatic ped(input bit expect_acc);
        ped_i = 1;
        if (expect_acc) exp_q.push_back(1'b1);
        tick(4);
        ped_i = 0;
        tick(4);
    endtask

    task automatic rearm();
        rearm_i = 1; tick(2); rearm_i = 0; tick(4);
    endtask

    // monitor: every accept must match the next expected kind (R7)
    initial begin
        forever begin
            @(negedge clk_i);
            if (rst_ni) begin
                if (wave_trig_o !== accept_o)
                    chk(1'b0, "R7 wave_trig follows accept", wave_trig_o, accept_o);
                if (accept_o) begin
                    if (exp_q.size() == 0) chk(1'b0, "R2/R3/R5 unexpected accept", 1, 0);
                    else begin
                        automatic bit k = exp_q.pop_front();
                        chk(ped_kind_o == k, "R7 accept kind", ped_kind_o, k);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        chk(accept_o == 0 && gate_o == 0 && busy_o == 0 && wave_trig_o == 0, "R10 reset outputs", busy_o, 0);
        chk(beam_cnt_o == 0 && ped_cnt_o == 0 && lost_cnt_o == 0, "R10 reset counters", beam_cnt_o, 0);
        rst_ni = 1;
        spill_i = 1;
        tick(5);

        // R1 latency, R4 busy, R6 gate width 4
        trg_a_i = 1; trg_b_i = 1; exp_q.push_back(1'b0);
        tick(2);
        chk(accept_o == 0, "R1 no accept before third edge", accept_o, 0);
        tick(1);
        chk(accept_o == 1, "R1 accept on third edge", accept_o, 1);
        chk(busy_o == 1, "R4 busy with accept", busy_o, 1);
        chk(gate_o == 1, "R6 gate opens", gate_o, 1);
        tick(3);
        chk(gate_o == 1, "R6 gate still open at cycle 4", gate_o, 1);
        tick(1);
        chk(gate_o == 0, "R6 gate closed after 4 cycles", gate_o, 0);
        trg_a_i = 0; trg_b_i = 0;
        tick(4);

        // R5 coincidence while busy is lost
        beam(1'b0);
        chk(busy_o == 1, "R4 busy holds without rearm", busy_o, 1);
        chk(lost_cnt_o == 1, "R5 lost counter", lost_cnt_o, 1);

        // R4 busy release timing
        rearm_i = 1;
        tick(2);
        chk(busy_o == 1, "R4 busy before third edge", busy_o, 1);
        tick(1);
        chk(busy_o == 0, "R4 busy cleared by rearm", busy_o, 0);
        rearm_i = 0;
        tick(3);

        // R2 veto and single counter
        veto_i = 1; tick(4);
        beam(1'b0);
        veto_i = 0; tick(4);
        trg_a_i = 1; tick(6); trg_a_i = 0; tick(4);
        chk(busy_o == 0, "R2 no busy after vetoed or single hits", busy_o, 0);

        // R3 spill gating
        ped(1'b0);
        chk(busy_o == 0, "R3 pedestal ignored in spill", busy_o, 0);
        spill_i = 0; tick(4);
        beam(1'b0);
        chk(busy_o == 0, "R3 beam ignored off spill", busy_o, 0);
        ped_veto_i = 1; tick(4);
        ped(1'b0);
        chk(busy_o == 0, "R3 pedestal veto", busy_o, 0);
        ped_veto_i = 0; tick(4);
        ped(1'b1);
        chk(busy_o == 1, "R3 pedestal accepted off spill", busy_o, 1);
        rearm();

        // R8 held coincidence does not retrigger
        spill_i = 1; tick(4);
        trg_a_i = 1; trg_b_i = 1; exp_q.push_back(1'b0);
        tick(6);
        rearm();
        tick(4);
        chk(busy_o == 0, "R8 held coincidence no retrigger", busy_o, 0);
        trg_a_i = 0; trg_b_i = 0; tick(4);
        beam(1'b1);
        chk(busy_o == 1, "R8 new edge accepted", busy_o, 1);
        rearm();

        // R6 width 0 -> one cycle
        gate_width_i = '0;
        trg_a_i = 1; trg_b_i = 1; exp_q.push_back(1'b0);
        tick(3);
        chk(gate_o == 1 && accept_o == 1, "R6 zero width gate opens", gate_o, 1);
        tick(1);
        chk(gate_o == 0, "R6 zero width gate one cycle", gate_o, 0);
        trg_a_i = 0; trg_b_i = 0; tick(4);
        rearm();

        // R9 counters and clear
        chk(beam_cnt_o == 4, "R9 beam count", beam_cnt_o, 4);
        chk(ped_cnt_o == 1, "R9 pedestal count", ped_cnt_o, 1);
        chk(lost_cnt_o == 1, "R5 lost count total", lost_cnt_o, 1);
        cnt_clr_i = 1; tick(1); cnt_clr_i = 0; tick(1);
        chk(beam_cnt_o == 0 && ped_cnt_o == 0 && lost_cnt_o == 0, "R9 counters cleared", beam_cnt_o + ped_cnt_o + lost_cnt_o, 0);

        chk(exp_q.size() == 0, "R1 all expected accepts seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule